// File: doc/BRIEF.md
# MDIO Management Master with Command Register

This block runs management-bus read and write transactions to external PHY devices. A host reaches it through a two-word register port. One word is the command word, which holds the operation, a 5-bit PHY address (so up to 32 devices) and a 5-bit register address. The other word is the data word. When the host writes the command word while the block is idle, it starts one 64-bit serial frame on the management clock and data lines.

The management clock is made by dividing the system clock by a parameterised ratio. The default is a fast setting, and a larger ratio gives the nominal 2.5 MHz rate. The line is driven on the falling edge of the management clock. Read data comes back on rising edges and is stored in the data word. A finished flag in the command word clears as soon as a command is accepted and sets only when the serial frame has ended. While a frame is in flight, the command word refuses host writes.

Top module: `mdio_cmd_master`

## Requirements
- R1: After synchronous reset the command word reads 0x8000 (finished flag set), the data word reads 0x0000, the management clock is low and the line is not driven.
- R2: A host write to address 0 while idle starts a transaction. The command word holds register address in bits [4:0], PHY address in bits [9:5] and the operation in bit [10] (1 = write, 0 = read). These fields read back unchanged, and bits [14:11] read as zero.
- R3: The finished flag (command word bit 15) reads 0 from the cycle after a command is accepted and returns to 1 only at the clock edge that ends the serial frame.
- R4: Host writes to the command word while a transaction is in flight are ignored. They change neither the stored fields nor the frame being sent.
- R5: The management clock has a period of 2*MDC_HALF system clocks, starts low, runs for exactly 64 periods per transaction and stays low while idle.
- R6: The frame, sent MSB first, is: 32 ones, start bits 01, opcode 10 for read or 01 for write, the PHY address, the register address, a 2-bit turnaround, and then 16 data bits.
- R7: While a transaction runs, the line output changes only at the system clock edge where the management clock falls.
- R8: For a read, the line is released from the first turnaround bit to the end of the frame. Sixteen bits are sampled MSB first at the rising management clock edges of the data phase, and the result is stored into the data word (address 1) at completion.
- R9: For a write, the line is driven for the whole frame, the turnaround is 10, and the data bits are the data word as it stood when the command was accepted. The host may write the data word at any time.
- R10: host_rdata is registered. It shows the word selected by host_addr one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 selects the command word, 1 selects the data word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data of the selected word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line, output enable |
| mdio_i | input | 1 | Management data line, input value |

## Verification
On every cycle the assertions check the command lock, the clearing and setting of the finished flag against the end of the frame, the quiet clock and released line while idle, and that the line changes only on a falling management clock edge. Only the bench's scenarios can show that the frame contents are correct bit for bit, that the read data assembled from the PHY's response lands in the data word, and that a write sends the data word captured at launch. The bench compares clock, line and read-back against its behavioural model over write and read transactions that use extreme addresses, and over a command write that arrives while the block is busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int FRAME_BITS = DATA_POS + DATA_W;
  localparam int OP_BIT     = 2 * ADDR_W;
  localparam int DONE_BIT   = DATA_W - 1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic [DATA_W-1:0] d);
    return {{PRE_BITS{1'b1}}, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regad,
            (c.wr ? 2'b10 : 2'b00), (c.wr ? d : {DATA_W{1'b0}})};
  endfunction
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick    = run && (cnt == CNT_END);
  assign rise_tk = tick && !mdc;
  assign fall_tk = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == CNT_END) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              mdio_i,
  output logic              busy,
  output logic              finish,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] OE_END   = IDX_W'(TA_POS - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  op_wr;

  assign finish = busy && fall_tk && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      op_wr   <= 1'b0;
      rd_data <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        sh      <= build_frame(cmd, wdata);
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
        idx     <= '0;
        op_wr   <= cmd.wr;
        rd_data <= '0;
      end
    end else begin
      if (rise_tk && !op_wr && (idx >= DATA_IDX))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (fall_tk) begin
        if (idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= idx + 1'b1;
          sh      <= sh << 1;
          mdio_o  <= sh[FRAME_BITS-2];
          mdio_oe <= op_wr || (idx < OE_END);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_hostregs.sv
module mdio_hostregs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              finish,
  input  logic [DATA_W-1:0] rd_data,
  output logic              launch,
  output mdio_cmd_t         cmd,
  output logic [DATA_W-1:0] data_q,
  output mdio_cmd_t         ctrl_fld,
  output logic              ctrl_done
);
  localparam int PAD_W = DATA_W - 1 - $bits(mdio_cmd_t);

  assign launch = host_wr && !host_addr && !busy;
  assign cmd    = mdio_cmd_t'(host_wdata[$bits(mdio_cmd_t)-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_fld   <= '0;
      ctrl_done  <= 1'b1;
      data_q     <= '0;
      host_rdata <= '0;
    end else begin
      if (launch) begin
        ctrl_fld  <= cmd;
        ctrl_done <= 1'b0;
      end
      if (finish)
        ctrl_done <= 1'b1;
      if (host_wr && host_addr)
        data_q <= host_wdata;
      if (finish && !ctrl_fld.wr)
        data_q <= rd_data;
      host_rdata <= host_addr ? data_q : {ctrl_done, {PAD_W{1'b0}}, ctrl_fld};
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              busy_w, finish_w, launch_w, rise_w, fall_w, ctrl_done_w;
  logic [DATA_W-1:0] rd_w, data_w;
  mdio_cmd_t         cmd_w, ctrl_fld_w;

  mdc_clkgen #(.HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst(rst), .run(busy_w),
    .mdc(mdc), .rise_tk(rise_w), .fall_tk(fall_w)
  );

  mdio_hostregs u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy_w), .finish(finish_w), .rd_data(rd_w),
    .launch(launch_w), .cmd(cmd_w), .data_q(data_w),
    .ctrl_fld(ctrl_fld_w), .ctrl_done(ctrl_done_w)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .start(launch_w), .cmd(cmd_w), .wdata(data_w),
    .rise_tk(rise_w), .fall_tk(fall_w), .mdio_i(mdio_i),
    .busy(busy_w), .finish(finish_w), .rd_data(rd_w),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk
  import mdio_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      host_wr,
  input logic      host_addr,
  input logic      busy,
  input logic      launch,
  input logic      done,
  input mdio_cmd_t fld,
  input logic      mdc,
  input logic      mdio_o,
  input logic      mdio_oe
);
  assert_launch_drives_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy && mdio_oe && mdio_o));

  assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
    launch |=> !done);

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  assert_cmd_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && !host_addr) |=> $stable(fld));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  assert_change_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .busy(busy_w), .launch(launch_w), .done(ctrl_done_w), .fld(ctrl_fld_w),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_cmd_master.sv
`timescale 1ns/1ps
module sim_mdio_cmd_master;
  localparam int H    = 3;
  localparam int TLEN = 128 * H;

  logic        clk = 1'b0, rst = 1'b1, host_wr = 1'b0, host_addr = 1'b0, mdio_i = 1'b1;
  logic [15:0] host_wdata = '0;
  wire  [15:0] host_rdata;
  wire         mdc, mdio_o, mdio_oe;

  always #2 clk = ~clk;

  mdio_cmd_master #(.MDC_HALF(H)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  bit          m_busy = 0, m_wr = 0, m_fin, was_busy, e_addr = 0;
  int          m_t = 0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_ctrl = 16'h8000, m_data = '0, e_rdata = '0, old_data, phy_val = '0;
  bit          p_mdc = 0, p_o = 0, p_busy = 0;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (time %0t)", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_t = 0; m_ctrl = 16'h8000; m_data = '0; e_rdata = '0;
    end else begin
      was_busy = m_busy;
      old_data = m_data;
      e_rdata  = host_addr ? m_data : m_ctrl;
      e_addr   = host_addr;
      m_fin    = m_busy && (m_t == TLEN - 1);
      if (m_busy) m_t++;
      if (host_wr && host_addr) m_data = host_wdata;
      if (m_fin) begin
        m_busy = 0; m_ctrl[15] = 1'b1;
        if (!m_wr) m_data = phy_val;
      end
      if (host_wr && !host_addr && !was_busy) begin
        m_ctrl  = {5'b0, host_wdata[10:0]};
        m_wr    = host_wdata[10];
        m_frame = {32'hFFFF_FFFF, 2'b01, (m_wr ? 2'b01 : 2'b10), host_wdata[9:5],
                   host_wdata[4:0], (m_wr ? 2'b10 : 2'b00), (m_wr ? old_data : 16'h0)};
        m_busy  = 1; m_t = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int  idx;
      bit  e_mdc, e_oe, e_o;
      idx   = m_t / (2 * H);
      e_mdc = m_busy && (((m_t / H) % 2) == 1);
      e_oe  = m_busy && (m_wr || idx < 46);
      e_o   = m_busy && m_frame[63 - idx];
      chk("R5 mdc", {15'b0, mdc}, {15'b0, e_mdc});
      chk(m_wr ? "R9 oe" : "R8 oe", {15'b0, mdio_oe}, {15'b0, e_oe});
      chk(m_wr ? "R9 mdio" : "R6 mdio", {15'b0, mdio_o}, {15'b0, e_o});
      chk(e_addr ? "R8 data word" : "R3 command word", host_rdata, e_rdata);
      if (m_busy && p_busy && (mdio_o !== p_o))
        chk("R7 change off falling edge", {15'b0, (p_mdc && !mdc)}, 16'h1);
      p_mdc = mdc; p_o = mdio_o; p_busy = m_busy;
      if (m_busy && !m_wr && idx >= 48) mdio_i = phy_val[63 - idx];
      else if (m_busy && !m_wr && idx == 47) mdio_i = 1'b0;
      else mdio_i = 1'b1;
    end
  end

  task automatic host_write(bit a, logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 command word after reset", host_rdata, 16'h8000);
    chk("R1 line released", {14'b0, mdc, mdio_oe}, 16'h0);
    host_addr = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 data word after reset", host_rdata, 16'h0000);

    // write, PHY 5, register 0x1A, data 0xBEEF
    host_write(1'b1, 16'hBEEF);
    host_write(1'b0, 16'h04BA);
    host_addr = 1'b0;
    @(negedge clk);
    chk("R2 R10 fields read back, flag clear", host_rdata, 16'h04BA);
    host_write(1'b0, 16'h0123);
    @(negedge clk);
    chk("R4 locked command unchanged", host_rdata, 16'h04BA);
    repeat (TLEN + 4) @(negedge clk);
    chk("R3 flag set after write", host_rdata, 16'h84BA);

    // read, PHY 31, register 0
    phy_val = 16'hA55A;
    host_write(1'b0, 16'h03E0);
    repeat (TLEN + 4) @(negedge clk);
    host_addr = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 read result stored", host_rdata, 16'hA55A);

    // read, PHY 0, register 31
    phy_val = 16'h0001;
    host_write(1'b0, 16'h001F);
    repeat (TLEN + 4) @(negedge clk);
    host_addr = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 second read result", host_rdata, 16'h0001);

    // write, PHY 17, register 3, data 0x8000
    host_write(1'b1, 16'h8000);
    host_write(1'b0, 16'h0623);
    host_write(1'b1, 16'h1234);
    repeat (TLEN + 4) @(negedge clk);
    host_addr = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 R3 write complete", host_rdata, 16'h8623);

    finished = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule